// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block sits between the command scheduler of a DRAM controller and the memory interface. It holds one packed, write-protectable timing register. From that register it enforces the minimum DRAM-clock spacing after three kinds of event: CKE rising out of power-down, CKE rising out of self-refresh, and a refresh command. The scheduler pulses an event strobe for one cycle when the event happens. It then issues a command of a given class only while the matching grant flag is high.

There are three grant flags. Read commands are gated by the power-down timer and the self-refresh read timer. Non-read commands are gated by the power-down timer and the self-refresh non-read timer. Activate and refresh commands must also clear the refresh-recovery timer.

Each timer loads when its event occurs. A programmed value N holds the affected grants low for exactly N cycles. Those cycles start with the cycle in which the strobe is high, so a value of 0 blocks nothing. A new event of the same kind reloads its timer, and the new count replaces the old one.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x03C80808 and all three grants are high while no event is pending. The fields hold power-down exit = 3 in bits 27:24, self-refresh read = 200 in bits 23:16, self-refresh non-read = 8 in bits 15:8, and refresh recovery = 8 in bits 6:0.
- R2: A write with `cfg_wp` low stores `cfg_wdata` from the next cycle onward, except that bits 31:28 and bit 7 always read as zero.
- R3: A write presented while `cfg_wp` is high leaves `cfg_rdata` unchanged.
- R4: A `pd_exit` strobe with power-down field P drives `rd_ok`, `nrd_ok` and `act_ok` low for P cycles. The strobe cycle is one of those P cycles.
- R5: An `sr_exit` strobe with read field D drives `rd_ok` low for D cycles, the strobe cycle included.
- R6: An `sr_exit` strobe with non-read field S drives `nrd_ok` and `act_ok` low for S cycles, the strobe cycle included.
- R7: A `ref_cmd` strobe with recovery field F drives `act_ok` low for F cycles, the strobe cycle included. It leaves `rd_ok` and `nrd_ok` unaffected.
- R8: A field programmed to 0 blocks nothing. In particular, a read field of 0 lets reads through in the self-refresh exit cycle itself.
- R9: A repeated event of the same kind restarts its window from the new strobe cycle, even when the old window has not ended.
- R10: Each grant is high only when every timer that applies to it is clear. An event uses the register value held before any write presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wp | input | 1 | Write protection; writes are dropped while high |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Current register contents |
| pd_exit | input | 1 | One-cycle pulse: CKE rose out of power-down |
| sr_exit | input | 1 | One-cycle pulse: CKE rose out of self-refresh |
| ref_cmd | input | 1 | One-cycle pulse: refresh command issued |
| rd_ok | output | 1 | Read command may issue this cycle |
| nrd_ok | output | 1 | Non-read command may issue this cycle |
| act_ok | output | 1 | Activate or refresh command may issue this cycle |

## Verification
Two functions can fall in the same cycle: a register write and an event strobe. The strobe must load the value held before the write. A directed case presents both together with different recovery values and checks the length of the blocked window. Overlapping windows are the other collision: a self-refresh exit, a refresh and a power-down exit land close together. Random stimulus produces both collisions often. A bench model records, for each window, the cycle in which it ends, and it judges every grant in every cycle against those end cycles.

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_wp,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        pd_exit,
  input  logic        sr_exit,
  input  logic        ref_cmd,
  output logic        rd_ok,
  output logic        nrd_ok,
  output logic        act_ok
);
  localparam logic [31:0] RST_VAL = 32'h03C8_0808;
  localparam logic [31:0] KEEP    = 32'h0FFF_FF7F;

  logic [31:0] cfg_q;
  logic [3:0]  t_pd;
  logic [7:0]  t_srd, t_snr;
  logic [6:0]  t_rfc;
  logic [3:0]  n_pd;
  logic [7:0]  n_srd, n_snr;
  logic [6:0]  n_rfc;
  logic        h_pd, h_srd, h_snr, h_rfc;

  assign n_pd  = cfg_q[27:24];
  assign n_srd = cfg_q[23:16];
  assign n_snr = cfg_q[15:8];
  assign n_rfc = cfg_q[6:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                cfg_q <= RST_VAL;
    else if (cfg_we && !cfg_wp) cfg_q <= cfg_wdata & KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_pd  <= '0;
      t_srd <= '0;
      t_snr <= '0;
      t_rfc <= '0;
    end else begin
      if (pd_exit)        t_pd <= (n_pd == 0) ? '0 : n_pd - 4'd1;
      else if (t_pd != 0) t_pd <= t_pd - 4'd1;

      if (sr_exit)         t_srd <= (n_srd == 0) ? '0 : n_srd - 8'd1;
      else if (t_srd != 0) t_srd <= t_srd - 8'd1;

      if (sr_exit)         t_snr <= (n_snr == 0) ? '0 : n_snr - 8'd1;
      else if (t_snr != 0) t_snr <= t_snr - 8'd1;

      if (ref_cmd)         t_rfc <= (n_rfc == 0) ? '0 : n_rfc - 7'd1;
      else if (t_rfc != 0) t_rfc <= t_rfc - 7'd1;
    end
  end

  assign h_pd  = pd_exit ? (n_pd  != 0) : (t_pd  != 0);
  assign h_srd = sr_exit ? (n_srd != 0) : (t_srd != 0);
  assign h_snr = sr_exit ? (n_snr != 0) : (t_snr != 0);
  assign h_rfc = ref_cmd ? (n_rfc != 0) : (t_rfc != 0);

  assign cfg_rdata = cfg_q;
  assign rd_ok     = !h_pd && !h_srd;
  assign nrd_ok    = !h_pd && !h_snr;
  assign act_ok    = nrd_ok && !h_rfc;
endmodule

// File: rtl/dram_cmd_guard_chk.sv
module dram_cmd_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        cfg_wp,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        pd_exit,
  input logic        sr_exit,
  input logic        ref_cmd,
  input logic        rd_ok,
  input logic        nrd_ok,
  input logic        act_ok
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:28] == 4'd0 && !cfg_rdata[7]); // R2
  AST_WR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wp |=> cfg_rdata == ($past(cfg_wdata) & 32'h0FFF_FF7F)); // R2
  AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wp |=> $stable(cfg_rdata)); // R3
  AST_PD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pd_exit && cfg_rdata[27:24] != 0 |-> !rd_ok && !nrd_ok && !act_ok); // R4
  AST_SRD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit && cfg_rdata[23:16] != 0 |-> !rd_ok); // R5
  AST_SNR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit && cfg_rdata[15:8] != 0 |-> !nrd_ok && !act_ok); // R6
  AST_RFC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd && cfg_rdata[6:0] != 0 |-> !act_ok); // R7
  AST_ACT_NEEDS_NRD: assert property (@(posedge clk) disable iff (!rst_n)
    act_ok |-> nrd_ok); // R10
  AST_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    act_ok && rd_ok |=> (pd_exit || sr_exit || ref_cmd) || (act_ok && rd_ok)); // R10
endmodule

bind dram_cmd_guard dram_cmd_guard_chk u_chk (.*);

// File: tb/test_dram_cmd_guard.sv
module test_dram_cmd_guard;
  localparam logic [31:0] KEEP = 32'h0FFF_FF7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_wp = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pd_exit = 1'b0, sr_exit = 1'b0, ref_cmd = 1'b0;
  logic        rd_ok, nrd_ok, act_ok;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R1";
  logic [31:0] mreg = 32'h03C8_0808;
  int cyc = 0, pd_end = 0, srd_end = 0, snr_end = 0, rfc_end = 0;

  always #10 clk = ~clk;

  dram_cmd_guard i_dram_cmd_guard (.*);

  task automatic chk(string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %h expected %h", tag, nm, cyc, act, exp);
    end
  endtask

  task automatic step();
    logic e_pd, e_rd, e_nrd, e_act;
    #5;
    if (pd_exit) pd_end = cyc + int'(mreg[27:24]);
    if (sr_exit) begin
      srd_end = cyc + int'(mreg[23:16]);
      snr_end = cyc + int'(mreg[15:8]);
    end
    if (ref_cmd) rfc_end = cyc + int'(mreg[6:0]);
    e_pd  = cyc < pd_end;
    e_rd  = !e_pd && !(cyc < srd_end);
    e_nrd = !e_pd && !(cyc < snr_end);
    e_act = e_nrd && !(cyc < rfc_end);
    chk("rd_ok", {31'd0, rd_ok}, {31'd0, e_rd});
    chk("nrd_ok", {31'd0, nrd_ok}, {31'd0, e_nrd});
    chk("act_ok", {31'd0, act_ok}, {31'd0, e_act});
    chk("cfg_rdata", cfg_rdata, mreg);
    if (cfg_we && !cfg_wp) mreg = cfg_wdata & KEEP;
    cyc++;
    @(negedge clk);
    pd_exit = 0; sr_exit = 0; ref_cmd = 0; cfg_we = 0;
  endtask

  task automatic wr(logic [31:0] v);
    cfg_we = 1; cfg_wdata = v;
    step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    chk("reset value", cfg_rdata, 32'h03C8_0808);
    step();
    tag = "R1"; pd_exit = 1; step(); repeat (4) step();
    tag = "R2"; wr(32'hFFFF_FFFF); step();
    chk("reserved bits", cfg_rdata & ~KEEP, 32'd0);
    tag = "R3"; cfg_wp = 1; wr(32'h0000_0000); step(); cfg_wp = 0;
    tag = "R4"; wr(32'h0500_0000); pd_exit = 1; step(); repeat (7) step();
    tag = "R5"; wr(32'h000C_0400); sr_exit = 1; step(); repeat (14) step();
    tag = "R6"; wr(32'h0002_0900); sr_exit = 1; step(); repeat (11) step();
    tag = "R7"; wr(32'h0000_0009); ref_cmd = 1; step(); repeat (11) step();
    tag = "R8"; wr(32'h0000_0000); pd_exit = 1; sr_exit = 1; ref_cmd = 1; step(); step();
    wr(32'h0000_0500); sr_exit = 1; step();
    chk("rd_ok after zero read field", {31'd0, rd_ok}, 32'd1);
    repeat (6) step();
    tag = "R9"; wr(32'h0000_0006); ref_cmd = 1; step(); repeat (3) step();
    ref_cmd = 1; step(); repeat (8) step();
    tag = "R10"; wr(32'h0000_0003); cfg_we = 1; cfg_wdata = 32'h0000_000A; ref_cmd = 1; step();
    repeat (12) step();
    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      pd_exit = ($urandom % 12) == 0;
      sr_exit = ($urandom % 20) == 0;
      ref_cmd = ($urandom % 8) == 0;
      cfg_wp  = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) begin
        cfg_we = 1;
        cfg_wdata = $urandom & 32'hF73F_3F3F;
      end
      step();
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule